// File: doc/BRIEF.md
# Digital audio sample conditioner

This block prepares stereo PCM for a biphase-mark frame encoder. Once per frame the encoder raises a strobe. In that cycle the conditioner accepts at most one left/right sample pair from the upstream sample FIFO through a ready/valid handshake. One cycle later it presents a pair of slot words with a one-cycle output strobe. The conditioner can place a narrow sample inside the wider slot, re-route or duplicate the channels, and mute either channel with a selectable constant word. It also drives the validity bit that goes with each subframe.

When the FIFO has nothing to offer at a strobe, the block still produces a frame. It substitutes data according to a programmable underrun policy: silence, the mute constant, or a replay of the last pair that really came from the FIFO. It also raises a one-cycle underrun pulse. A hold control freezes the whole output side: nothing is consumed and the slot words keep their values.

Top module: `audio_slot_conditioner`

## Requirements
- R1: `in_ready` is high exactly in cycles where `frame_stb` is high and `cfg_hold` is low. A pair is taken when `in_valid` is also high, so at most one pair is taken per strobe. Such a strobe produces a one-cycle `slot_stb` in the next cycle, together with the new slot words.
- R2: With `cfg_narrow` = 1 only bits [15:0] of each input sample are used. `cfg_align` = 0 puts them in slot bits [15:0] with the bits above them zero. Code 1 puts them in [19:4] with zeros in [23:20] and [3:0]. Code 2 puts them in [23:8] with zeros in [7:0]. Code 3 acts as code 0.
- R3: With `cfg_narrow` = 0 the 24-bit input sample reaches the slot unchanged, whatever `cfg_align` holds.
- R4: `cfg_mute_code` selects the mute word as follows: 0 gives 0x000000, 1 gives 0x800000, 2 gives 0x080000, 3 gives 0x008000, 4 gives 0x000001, 5 gives 0x000010, 6 gives 0x000100, and 7 gives 0x000000.
- R5: `cfg_mute_l` (`cfg_mute_r`) replaces the left (right) output slot with the mute word. Muting is applied after channel routing.
- R6: `cfg_route` sets the channel routing: 0 keeps the order, 1 exchanges left and right, 2 sends the left sample to both slots, and 3 sends the right sample to both slots.
- R7: On a strobe without `in_valid`, `cfg_underrun` decides the substitute pair. Code 0 gives zero on both channels, code 1 gives the mute word on both channels, and code 3 acts as code 0. Routing and muting are then applied as usual.
- R8: Under `cfg_underrun` code 2 the substitute pair is the most recent consumed pair, after placement and before routing and muting. This stored pair changes only when a pair is consumed, and it is zero after reset.
- R9: `underrun` pulses for exactly one cycle, together with `slot_stb`, for each non-held strobe that found no valid input.
- R10: While `cfg_hold` is high a strobe consumes nothing, raises neither `slot_stb` nor `underrun`, and leaves the slot words and the validity output unchanged.
- R11: On each output frame `slot_vbit` carries `cfg_vbit` if `cfg_vbit_en` was high at the strobe, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | Frame request from the encoder |
| in_valid | input | 1 | FIFO has a pair available |
| in_ready | output | 1 | Pair accepted this cycle |
| in_left | input | 24 | Left input sample |
| in_right | input | 24 | Right input sample |
| cfg_narrow | input | 1 | Inputs are 16-bit samples |
| cfg_align | input | 2 | Placement of narrow samples |
| cfg_route | input | 2 | Channel routing code |
| cfg_mute_l | input | 1 | Mute left slot |
| cfg_mute_r | input | 1 | Mute right slot |
| cfg_mute_code | input | 3 | Mute word selector |
| cfg_underrun | input | 2 | Underrun substitution policy |
| cfg_hold | input | 1 | Freeze output interface |
| cfg_vbit | input | 1 | Validity bit value |
| cfg_vbit_en | input | 1 | Send the validity value |
| slot_left | output | 24 | Left slot word |
| slot_right | output | 24 | Right slot word |
| slot_stb | output | 1 | New slot words present |
| slot_vbit | output | 1 | Validity bit for both subframes |
| underrun | output | 1 | Substitute data was sent |

## Verification
The bench sweeps every combination of placement, routing, both mute flags, all eight mute codes and all four underrun codes, with and without valid input. It covers the reserved codes 3 and 7, which a design that decoded them as live values would turn into a shifted word or a stale replay. Replay is checked straight after reset, and also after a held strobe that offered data. A design whose stored pair did not start at zero, or that captured samples while held, would replay the wrong pair. Checking one cycle after each frame catches an underrun or strobe pulse that lasts too long, as well as a routing that mutes before it swaps.

// File: rtl/acnd_pkg.sv
package acnd_pkg;
   typedef enum logic [1:0] {
      ALN_LOW    = 2'd0,
      ALN_CENTRE = 2'd1,
      ALN_HIGH   = 2'd2,
      ALN_RSVD   = 2'd3
   } align_e;

   typedef enum logic [1:0] {
      RT_PASS  = 2'd0,
      RT_CROSS = 2'd1,
      RT_DUP_L = 2'd2,
      RT_DUP_R = 2'd3
   } route_e;

   typedef enum logic [1:0] {
      UR_ZERO   = 2'd0,
      UR_MUTE   = 2'd1,
      UR_REPLAY = 2'd2,
      UR_RSVD   = 2'd3
   } starve_e;
endpackage

// File: rtl/acnd_align.sv
module acnd_align #(
   parameter int SAMPLE_W = 24,
   parameter int NARROW_W = 16
) (
   input  logic [SAMPLE_W-1:0] din,
   input  logic                narrow,
   input  logic [1:0]          align,
   output logic [SAMPLE_W-1:0] dout
);
   import acnd_pkg::*;
   localparam int PAD_W  = SAMPLE_W - NARROW_W;
   localparam int HALF_W = PAD_W / 2;

   logic [NARROW_W-1:0] s;
   logic [SAMPLE_W-1:0] placed;

   assign s = din[NARROW_W-1:0];

   always_comb begin
      case (align_e'(align))
         ALN_CENTRE: placed = {{HALF_W{1'b0}}, s, {HALF_W{1'b0}}};
         ALN_HIGH:   placed = {s, {PAD_W{1'b0}}};
         default:    placed = {{PAD_W{1'b0}}, s};
      endcase
   end

   assign dout = narrow ? placed : din;
endmodule

// File: rtl/acnd_route.sv
module acnd_route #(
   parameter int SAMPLE_W = 24
) (
   input  logic [SAMPLE_W-1:0] a_left,
   input  logic [SAMPLE_W-1:0] a_right,
   input  logic [1:0]          route,
   input  logic                mute_l,
   input  logic                mute_r,
   input  logic [SAMPLE_W-1:0] mute_word,
   output logic [SAMPLE_W-1:0] o_left,
   output logic [SAMPLE_W-1:0] o_right
);
   import acnd_pkg::*;
   logic [SAMPLE_W-1:0] r_left, r_right;

   always_comb begin
      case (route_e'(route))
         RT_CROSS: begin r_left = a_right; r_right = a_left;  end
         RT_DUP_L: begin r_left = a_left;  r_right = a_left;  end
         RT_DUP_R: begin r_left = a_right; r_right = a_right; end
         default:  begin r_left = a_left;  r_right = a_right; end
      endcase
   end

   assign o_left  = mute_l ? mute_word : r_left;
   assign o_right = mute_r ? mute_word : r_right;
endmodule

// File: rtl/audio_slot_conditioner.sv
module audio_slot_conditioner #(
   parameter int SAMPLE_W = 24,
   parameter int NARROW_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_stb,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   input  logic                cfg_narrow,
   input  logic [1:0]          cfg_align,
   input  logic [1:0]          cfg_route,
   input  logic                cfg_mute_l,
   input  logic                cfg_mute_r,
   input  logic [2:0]          cfg_mute_code,
   input  logic [1:0]          cfg_underrun,
   input  logic                cfg_hold,
   input  logic                cfg_vbit,
   input  logic                cfg_vbit_en,
   output logic [SAMPLE_W-1:0] slot_left,
   output logic [SAMPLE_W-1:0] slot_right,
   output logic                slot_stb,
   output logic                slot_vbit,
   output logic                underrun
);
   import acnd_pkg::*;
   localparam int NCH   = 2;
   localparam int PAD_W = SAMPLE_W - NARROW_W;

   generate
      if (PAD_W <= 0 || (PAD_W % 2) != 0) begin : g_bad_pad
         $error("slot must exceed narrow width by an even, positive count");
      end
      if (SAMPLE_W < 9) begin : g_bad_width
         $error("slot width too small for the mute word table");
      end
   endgenerate

   function automatic logic [SAMPLE_W-1:0] mute_lookup(input logic [2:0] code);
      logic [SAMPLE_W-1:0] one;
      one = {{(SAMPLE_W-1){1'b0}}, 1'b1};
      case (code)
         3'd1:    return one << (SAMPLE_W - 1);
         3'd2:    return one << (SAMPLE_W - 5);
         3'd3:    return one << (SAMPLE_W - 9);
         3'd4:    return one;
         3'd5:    return one << 4;
         3'd6:    return one << 8;
         default: return '0;
      endcase
   endfunction

   logic                          take, starve, fire;
   logic [NCH-1:0][SAMPLE_W-1:0]  raw, placed, last_q, src;
   logic [SAMPLE_W-1:0]           mute_word;
   logic [SAMPLE_W-1:0]           nx_left, nx_right;

   assign in_ready = frame_stb & ~cfg_hold;
   assign fire     = in_ready;
   assign take     = in_ready & in_valid;
   assign starve   = in_ready & ~in_valid;
   assign raw[0]   = in_left;
   assign raw[1]   = in_right;
   assign mute_word = mute_lookup(cfg_mute_code);

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
         acnd_align #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W)) u_align (
            .din    (raw[ch]),
            .narrow (cfg_narrow),
            .align  (cfg_align),
            .dout   (placed[ch])
         );

         always_ff @(posedge clk) begin
            if (!rst_n)    last_q[ch] <= '0;
            else if (take) last_q[ch] <= placed[ch];
         end

         always_comb begin
            if (in_valid) src[ch] = placed[ch];
            else begin
               case (starve_e'(cfg_underrun))
                  UR_MUTE:   src[ch] = mute_word;
                  UR_REPLAY: src[ch] = last_q[ch];
                  default:   src[ch] = '0;
               endcase
            end
         end
      end
   endgenerate

   acnd_route #(.SAMPLE_W(SAMPLE_W)) u_route (
      .a_left    (src[0]),
      .a_right   (src[1]),
      .route     (cfg_route),
      .mute_l    (cfg_mute_l),
      .mute_r    (cfg_mute_r),
      .mute_word (mute_word),
      .o_left    (nx_left),
      .o_right   (nx_right)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_left  <= '0;
         slot_right <= '0;
         slot_vbit  <= 1'b0;
         slot_stb   <= 1'b0;
         underrun   <= 1'b0;
      end else begin
         slot_stb <= fire;
         underrun <= starve;
         if (fire) begin
            slot_left  <= nx_left;
            slot_right <= nx_right;
            slot_vbit  <= cfg_vbit_en & cfg_vbit;
         end
      end
   end
endmodule

// File: rtl/acnd_chk.sv
module acnd_chk #(
   parameter int SAMPLE_W = 24
) (
   input logic                clk,
   input logic                rst_n,
   input logic                frame_stb,
   input logic                in_valid,
   input logic                in_ready,
   input logic                cfg_hold,
   input logic                cfg_mute_l,
   input logic                cfg_mute_r,
   input logic [2:0]          cfg_mute_code,
   input logic                cfg_vbit,
   input logic                cfg_vbit_en,
   input logic [SAMPLE_W-1:0] slot_left,
   input logic [SAMPLE_W-1:0] slot_right,
   input logic                slot_stb,
   input logic                slot_vbit,
   input logic                underrun
);
   function automatic logic [SAMPLE_W-1:0] expect_mute(input logic [2:0] c);
      logic [SAMPLE_W-1:0] w;
      w = '0;
      if (c == 3'd1) w[SAMPLE_W-1] = 1'b1;
      if (c == 3'd2) w[SAMPLE_W-5] = 1'b1;
      if (c == 3'd3) w[SAMPLE_W-9] = 1'b1;
      if (c == 3'd4) w[0] = 1'b1;
      if (c == 3'd5) w[4] = 1'b1;
      if (c == 3'd6) w[8] = 1'b1;
      return w;
   endfunction

   // R1
   stb_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && !cfg_hold) |=> slot_stb);

   // R9
   underrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> slot_stb && !$past(in_valid) && !$past(cfg_hold));

   // R10
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hold |=> !slot_stb && !underrun && $stable(slot_left)
                   && $stable(slot_right) && $stable(slot_vbit));

   // R10
   hold_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hold |-> !in_ready);

   // R5
   mute_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && !cfg_hold && cfg_mute_l) |=> slot_left == expect_mute($past(cfg_mute_code)));

   // R5
   mute_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && !cfg_hold && cfg_mute_r) |=> slot_right == expect_mute($past(cfg_mute_code)));

   // R11
   vbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && !cfg_hold) |=> slot_vbit == ($past(cfg_vbit) && $past(cfg_vbit_en)));
endmodule

bind audio_slot_conditioner acnd_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/sim_audio_slot_conditioner.sv
`timescale 1ns/100ps
module sim_audio_slot_conditioner;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_stb = 1'b0, in_valid = 1'b0;
   logic        in_ready;
   logic [23:0] in_left = '0, in_right = '0;
   logic        cfg_narrow = 1'b0;
   logic [1:0]  cfg_align = '0, cfg_route = '0, cfg_underrun = '0;
   logic        cfg_mute_l = 1'b0, cfg_mute_r = 1'b0;
   logic [2:0]  cfg_mute_code = '0;
   logic        cfg_hold = 1'b0, cfg_vbit = 1'b0, cfg_vbit_en = 1'b0;
   logic [23:0] slot_left, slot_right;
   logic        slot_stb, slot_vbit, underrun;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [23:0] last_l = '0, last_r = '0;

   always #2.5 clk = ~clk;

   audio_slot_conditioner u0 (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .in_valid(in_valid),
      .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
      .cfg_narrow(cfg_narrow), .cfg_align(cfg_align), .cfg_route(cfg_route),
      .cfg_mute_l(cfg_mute_l), .cfg_mute_r(cfg_mute_r), .cfg_mute_code(cfg_mute_code),
      .cfg_underrun(cfg_underrun), .cfg_hold(cfg_hold), .cfg_vbit(cfg_vbit),
      .cfg_vbit_en(cfg_vbit_en), .slot_left(slot_left), .slot_right(slot_right),
      .slot_stb(slot_stb), .slot_vbit(slot_vbit), .underrun(underrun)
   );

   task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [23:0] mw(input int c);
      if (c >= 1 && c <= 3) return 24'(1) << (27 - 4 * c);
      if (c >= 4 && c <= 6) return 24'(1) << (4 * (c - 4));
      return 24'h0;
   endfunction

   function automatic logic [23:0] place(input logic [23:0] x, input bit n, input int a);
      if (!n) return x;
      if (a == 1) return 24'(x[15:0]) << 4;
      if (a == 2) return 24'(x[15:0]) << 8;
      return 24'(x[15:0]);
   endfunction

   // one strobe; configuration already applied; called at a negedge
   task automatic frame(input bit v, input logic [23:0] l, input logic [23:0] r, input string tag);
      logic [23:0] sl, sr, el, er;
      bit ev;
      if (v) begin
         sl = place(l, cfg_narrow, int'(cfg_align));
         sr = place(r, cfg_narrow, int'(cfg_align));
      end else if (cfg_underrun == 2'd1) begin
         sl = mw(int'(cfg_mute_code)); sr = sl;
      end else if (cfg_underrun == 2'd2) begin
         sl = last_l; sr = last_r;
      end else begin
         sl = '0; sr = '0;
      end
      case (cfg_route)
         2'd1: begin el = sr; er = sl; end
         2'd2: begin el = sl; er = sl; end
         2'd3: begin el = sr; er = sr; end
         default: begin el = sl; er = sr; end
      endcase
      if (cfg_mute_l) el = mw(int'(cfg_mute_code));
      if (cfg_mute_r) er = mw(int'(cfg_mute_code));
      ev = cfg_vbit & cfg_vbit_en;
      frame_stb = 1'b1; in_valid = v; in_left = l; in_right = r;
      #1;
      chk(in_ready == 1'b1, "R1 ready", 48'(in_ready), 48'd1);
      @(posedge clk); @(negedge clk);
      frame_stb = 1'b0; in_valid = 1'b0;
      if (v) begin last_l = place(l, cfg_narrow, int'(cfg_align)); last_r = place(r, cfg_narrow, int'(cfg_align)); end
      chk(slot_stb == 1'b1, "R1 stb", 48'(slot_stb), 48'd1);
      chk(underrun == !v, "R9 flag", 48'(underrun), 48'(!v));
      chk({slot_left, slot_right} == {el, er}, tag, {slot_left, slot_right}, {el, er});
      chk(slot_vbit == ev, "R11 vbit", 48'(slot_vbit), 48'(ev));
      @(posedge clk); @(negedge clk);
      chk(!slot_stb && !underrun, "R9 one-cycle", 48'({slot_stb, underrun}), 48'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int it;
      logic [47:0] held;
      repeat (3) @(negedge clk);
      chk({slot_left, slot_right, slot_stb, underrun, slot_vbit} == '0, "R1 reset",
          48'({slot_stb, underrun, slot_vbit}), 48'd0);
      chk(in_ready == 1'b0, "R1 idle ready", 48'(in_ready), 48'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // replay straight after reset gives the zero pair
      cfg_underrun = 2'd2;
      frame(1'b0, 24'h0, 24'h0, "R8 reset replay");

      it = 0;
      for (int n = 0; n < 2; n++)
       for (int al = 0; al < 4; al++)
        for (int sw = 0; sw < 4; sw++)
         for (int mm = 0; mm < 4; mm++)
          for (int mc = 0; mc < 8; mc++)
           for (int up = 0; up < 4; up++)
            for (int v = 0; v < 2; v++) begin
               string tag;
               cfg_narrow = n[0]; cfg_align = al[1:0]; cfg_route = sw[1:0];
               cfg_mute_l = mm[0]; cfg_mute_r = mm[1]; cfg_mute_code = mc[2:0];
               cfg_underrun = up[1:0]; cfg_vbit = it[0]; cfg_vbit_en = it[1];
               if (mm != 0)      tag = (mc == 7 || mc == 0) ? "R4 mute table" : "R5 mute";
               else if (v == 0)  tag = (up == 2) ? "R8 replay" : "R7 underrun";
               else if (sw != 0) tag = "R6 route";
               else if (n == 1)  tag = "R2 placement";
               else              tag = "R3 passthrough";
               frame(v[0], 24'(it * 40503) ^ 24'h5A3C91, 24'(it * 7919) + 24'h13579B, tag);
               it++;
            end

      // hold: offered data is not taken and the slots freeze
      cfg_mute_l = 1'b0; cfg_mute_r = 1'b0; cfg_route = 2'd0;
      cfg_narrow = 1'b0; cfg_underrun = 2'd2; cfg_vbit = 1'b1; cfg_vbit_en = 1'b1;
      frame(1'b1, 24'hABCDEF, 24'h123456, "R3 passthrough pre-hold");
      held = {slot_left, slot_right};
      cfg_hold = 1'b1; cfg_vbit_en = 1'b0;
      frame_stb = 1'b1; in_valid = 1'b1; in_left = 24'h777777; in_right = 24'h888888;
      #1;
      chk(in_ready == 1'b0, "R10 ready", 48'(in_ready), 48'd0);
      @(posedge clk); @(negedge clk);
      frame_stb = 1'b0; in_valid = 1'b0;
      chk(!slot_stb && !underrun, "R10 strobes", 48'({slot_stb, underrun}), 48'd0);
      chk({slot_left, slot_right} == held, "R10 slots", {slot_left, slot_right}, held);
      chk(slot_vbit == 1'b1, "R10 vbit", 48'(slot_vbit), 48'd1);
      cfg_hold = 1'b0; cfg_vbit_en = 1'b1;
      // replay must return the pre-hold pair, not the held offer
      frame(1'b0, 24'h0, 24'h0, "R8 replay after hold");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule